// File: doc/BRIEF.md
# Projected-Waveform Transaction Queue

This block keeps the projected future of one signal driver as a short list of value/time transactions in strictly increasing time order, together with the value the driver presents now. The list changes in two ways. A client schedules a new transaction. A free-running current-time input catches up with the oldest pending entry. When the current time reaches the head entry's time, that entry leaves the list and its value becomes the driven value.

Each schedule request carries a value, an absolute time, a mode bit and a rejection limit. Every pending entry at or after the new time is discarded first. In transport mode the new entry then goes at the tail. In inertial mode a marking pass runs before the append. The pass keeps old entries whose time plus the rejection limit is still earlier than the new time. It also keeps the run of entries just ahead of the new one that carry the same value. All other entries pending at that point are removed. The driven value itself is never removed. A request takes a few cycles, with at most one scan cycle per stored entry, and `busy` is high while it runs.

Top module: `wfq_projq`

## Requirements
- R1: After a synchronous active-low reset, `drv_val` is 0, `busy` is 0, `sched_drop` is 0 and the list is empty.
- R2: When the list is non-empty and `now` is greater than or equal to the head entry's time, the head entry is removed at that clock edge and its value appears on `drv_val` after the edge. `drv_val` changes at no other time, and the stored times are always strictly increasing.
- R3: In transport mode (`sched_inertial` = 0), a new entry whose time is later than every stored entry is appended at the tail, and all stored entries are kept.
- R4: On any accepted request, every stored entry whose time is greater than or equal to the new time is deleted before the new entry is placed. A second request whose time is at most that of a first request therefore replaces the first, whatever the mode.
- R5: In inertial mode (`sched_inertial` = 1), a surviving old entry is kept if its time plus `sched_reject` is strictly less than the new time, with the sum evaluated without overflow. If `sched_reject` exceeds the new time, no entry is kept on this ground.
- R6: In inertial mode, an old entry that is not kept under R5 is kept if every entry from it up to the new one has the same value as the new one. Every other old entry is deleted.
- R7: Inertial mode with `sched_reject` = 0 yields the same list as transport mode.
- R8: If the list holds DEPTH entries once the deletions are done, the new entry is dropped, the deletions still take effect, and `sched_drop` is high for exactly one cycle, in the cycle after the request completes.
- R9: A transport request keeps `busy` high for 1 cycle after acceptance. An inertial request keeps it high for 2 + c cycles, where c is the number of entries kept under R6 alone. `sched_ready` is low whenever `busy` is high.
- R10: In any cycle in which a head removal (R2) takes place, `sched_ready` is low and the request is not taken.
- R11: Cycles in which `busy` is high and no removal happens number at most DEPTH + 2 per request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| now | input | TIME_W | Current time |
| sched_valid | input | 1 | Request present |
| sched_val | input | VAL_W | Value of the new transaction |
| sched_time | input | TIME_W | Absolute time of the new transaction |
| sched_inertial | input | 1 | 0 = transport, 1 = inertial |
| sched_reject | input | TIME_W | Rejection limit for inertial mode |
| sched_ready | output | 1 | Request is taken at this edge when high together with sched_valid |
| busy | output | 1 | A request is being processed |
| sched_drop | output | 1 | One-cycle pulse: the last request's entry was dropped because the list was full |
| drv_val | output | VAL_W | Value currently driven |

## Verification
The bench changes `now` 1 ns after a rising edge and samples at falling edges. A head entry with time t therefore reaches `drv_val` at the edge following the cycle in which `now` equals t, and the monitor sees the change while `now` reads t+1. The scoreboard stores that instant with each expected value and compares both. The request task counts `busy` cycles from the first falling edge after the accepting edge and compares the count with the 1 or 2 + c cycles that R9 predicts. It reads `sched_drop` at the first falling edge with `busy` low, which is exactly where the one-cycle pulse lands. For the removal-priority case, the task drives `now` onto the head time in the same cycle as a request and checks that `sched_ready` is low before that edge and high one cycle later.

// File: rtl/wfq_pkg.sv
// Shared types for the projected-waveform transaction queue.
package wfq_pkg;

    // Control phases of a schedule request.
    typedef enum logic [1:0] {
        WQ_IDLE   = 2'd0,   // ready for a new request
        WQ_SCAN   = 2'd1,   // inertial marking, walking backwards
        WQ_COMMIT = 2'd2    // compact survivors and append
    } wq_state_e;

endpackage

// File: rtl/wfq_mark.sv
// wfq_mark: per-entry time comparisons against a reference time.
// For every stored entry below `count` it reports whether the entry lies
// strictly before the reference time, and whether its time plus the
// rejection limit still lies strictly before it (time mark). Both results
// are also counted. Assumes stored times are strictly increasing, so both
// sets form a prefix of the list and their counts give the prefix lengths.
module wfq_mark #(
    parameter int DEPTH  = 8,
    parameter int TIME_W = 32,
    parameter int CNT_W  = $clog2(DEPTH + 1)
) (
    input  logic [DEPTH-1:0][TIME_W-1:0] ent_time,
    input  logic [CNT_W-1:0]             count,
    input  logic [TIME_W-1:0]            ref_time,
    input  logic [TIME_W-1:0]            reject,
    output logic [DEPTH-1:0]             tmark,
    output logic [CNT_W-1:0]             n_earlier,
    output logic [CNT_W-1:0]             n_tmark
);

    logic [DEPTH-1:0] earlier;

    for (genvar g = 0; g < DEPTH; g++) begin : g_cmp
        logic live;
        logic [TIME_W:0] shifted;
        assign live       = (CNT_W'(g) < count);
        assign shifted    = {1'b0, ent_time[g]} + {1'b0, reject};
        assign earlier[g] = live && (ent_time[g] < ref_time);
        assign tmark[g]   = live && (shifted < {1'b0, ref_time});
    end

    // Population counts of both prefixes.
    always_comb begin
        n_earlier = '0;
        n_tmark   = '0;
        for (int i = 0; i < DEPTH; i++) begin
            n_earlier = n_earlier + CNT_W'(earlier[i]);
            n_tmark   = n_tmark + CNT_W'(tmark[i]);
        end
    end

endmodule

// File: rtl/wfq_store.sv
// wfq_store: the transaction list itself.
// Holds up to DEPTH value/time entries, index 0 being the oldest. One
// operation per cycle, in priority order: pop the head, truncate to a given
// length, or commit. A commit keeps entries [0, keep_lo) and
// [keep_from, count), packs them together and appends the new entry unless
// the packed list is already full. Assumes keep_lo <= keep_from <= count and
// that the caller only pops a non-empty list.
module wfq_store #(
    parameter int DEPTH  = 8,
    parameter int VAL_W  = 16,
    parameter int TIME_W = 32,
    parameter int CNT_W  = $clog2(DEPTH + 1),
    parameter int IDX_W  = $clog2(DEPTH)
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         pop,
    input  logic                         trunc_en,
    input  logic [CNT_W-1:0]             trunc_cnt,
    input  logic                         commit_en,
    input  logic [CNT_W-1:0]             keep_lo,
    input  logic [CNT_W-1:0]             keep_from,
    input  logic [VAL_W-1:0]             new_val,
    input  logic [TIME_W-1:0]            new_time,
    output logic [DEPTH-1:0][VAL_W-1:0]  ent_val,
    output logic [DEPTH-1:0][TIME_W-1:0] ent_time,
    output logic [CNT_W-1:0]             count,
    output logic                         commit_full
);

    logic [DEPTH-1:0][VAL_W-1:0]  nxt_val;
    logic [DEPTH-1:0][TIME_W-1:0] nxt_time;
    int kept_i;

    // Build the packed list that a commit would produce.
    always_comb begin
        kept_i      = int'(keep_lo) + int'(count) - int'(keep_from);
        commit_full = (kept_i >= DEPTH);
        for (int j = 0; j < DEPTH; j++) begin
            int src;
            src         = (j < int'(keep_lo)) ? j : j + int'(keep_from) - int'(keep_lo);
            nxt_val[j]  = '0;
            nxt_time[j] = '0;
            if (j < kept_i) begin
                if (src < DEPTH) begin
                    nxt_val[j]  = ent_val[src[IDX_W-1:0]];
                    nxt_time[j] = ent_time[src[IDX_W-1:0]];
                end
            end else if (j == kept_i && !commit_full) begin
                nxt_val[j]  = new_val;
                nxt_time[j] = new_time;
            end
        end
    end

    // Apply pop, truncation or commit to the stored list.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ent_val  <= '0;
            ent_time <= '0;
            count    <= '0;
        end else if (pop) begin
            for (int i = 0; i < DEPTH - 1; i++) begin
                ent_val[i]  <= ent_val[i+1];
                ent_time[i] <= ent_time[i+1];
            end
            ent_val[DEPTH-1]  <= '0;
            ent_time[DEPTH-1] <= '0;
            count             <= count - 1'b1;
        end else if (trunc_en) begin
            count <= trunc_cnt;
        end else if (commit_en) begin
            ent_val  <= nxt_val;
            ent_time <= nxt_time;
            count    <= CNT_W'(commit_full ? kept_i : kept_i + 1);
        end
    end

    // R2: stored times stay strictly increasing.
    for (genvar g = 0; g < DEPTH - 1; g++) begin : g_order
        a_r2_sorted: assert property (@(posedge clk) disable iff (!rst_n)
            (int'(count) > g + 1) |-> (ent_time[g] < ent_time[g+1]));
    end

    // R2: the list never claims more than DEPTH entries.
    a_r2_count_range: assert property (@(posedge clk) disable iff (!rst_n)
        int'(count) <= DEPTH);

endmodule

// File: rtl/wfq_projq.sv
// wfq_projq: projected-waveform transaction queue (top).
// Accepts one schedule request at a time. In the accept cycle it truncates
// the list to the entries that lie strictly before the new time. Transport
// requests then commit. Inertial requests first walk backwards from the tail
// for as long as entries repeat the new value and are not time-marked. The
// commit keeps the time-marked prefix plus that same-value suffix and appends
// the new entry. The head entry is popped whenever `now` has reached its
// time. A pop freezes the request sequencer for that cycle, and it blocks
// acceptance of a new request.
module wfq_projq #(
    parameter int DEPTH  = 8,
    parameter int VAL_W  = 16,
    parameter int TIME_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [TIME_W-1:0] now,
    input  logic              sched_valid,
    input  logic [VAL_W-1:0]  sched_val,
    input  logic [TIME_W-1:0] sched_time,
    input  logic              sched_inertial,
    input  logic [TIME_W-1:0] sched_reject,
    output logic              sched_ready,
    output logic              busy,
    output logic              sched_drop,
    output logic [VAL_W-1:0]  drv_val
);
    import wfq_pkg::*;

    localparam int CNT_W = $clog2(DEPTH + 1);
    localparam int IDX_W = $clog2(DEPTH);
    localparam int RUN_W = $clog2(DEPTH + 4) + 1;

    wq_state_e                    state;
    logic [VAL_W-1:0]             req_val;
    logic [TIME_W-1:0]            req_time;
    logic [TIME_W-1:0]            req_rej;
    logic                         req_inert;
    logic [CNT_W-1:0]             s_ptr;
    logic [CNT_W-1:0]             s_dec;
    logic [IDX_W-1:0]             s_idx;

    logic [DEPTH-1:0][VAL_W-1:0]  ent_val;
    logic [DEPTH-1:0][TIME_W-1:0] ent_time;
    logic [CNT_W-1:0]             q_count;
    logic                         commit_full;
    logic [DEPTH-1:0]             tmark;
    logic [CNT_W-1:0]             n_earlier;
    logic [CNT_W-1:0]             n_tmark;
    logic [TIME_W-1:0]            ref_time;
    logic                         pop_fire;
    logic                         accept;
    logic                         commit_en;
    logic                         scan_stop;
    logic [CNT_W-1:0]             keep_lo;
    logic [CNT_W-1:0]             keep_from;

    // Head removal and request handshake.
    assign pop_fire    = (q_count != '0) && (now >= ent_time[0]);
    assign busy        = (state != WQ_IDLE);
    assign sched_ready = !busy && !pop_fire;
    assign accept      = sched_valid && sched_ready;
    assign commit_en   = (state == WQ_COMMIT) && !pop_fire;

    // Compare against the incoming time while idle and the latched time later.
    assign ref_time = (state == WQ_IDLE) ? sched_time : req_time;

    // Scan cursor: entry s_ptr-1 is the next candidate for the same-value run.
    assign s_dec     = s_ptr - 1'b1;
    assign s_idx     = s_dec[IDX_W-1:0];
    assign scan_stop = (s_ptr == '0) || tmark[s_idx] || (ent_val[s_idx] != req_val);

    // Survivor ranges handed to the store at commit.
    assign keep_lo   = req_inert ? n_tmark : q_count;
    assign keep_from = req_inert ? s_ptr   : q_count;

    wfq_mark #(
        .DEPTH (DEPTH),
        .TIME_W(TIME_W),
        .CNT_W (CNT_W)
    ) u_mark (
        .ent_time (ent_time),
        .count    (q_count),
        .ref_time (ref_time),
        .reject   (req_rej),
        .tmark    (tmark),
        .n_earlier(n_earlier),
        .n_tmark  (n_tmark)
    );

    wfq_store #(
        .DEPTH (DEPTH),
        .VAL_W (VAL_W),
        .TIME_W(TIME_W),
        .CNT_W (CNT_W),
        .IDX_W (IDX_W)
    ) u_store (
        .clk        (clk),
        .rst_n      (rst_n),
        .pop        (pop_fire),
        .trunc_en   (accept),
        .trunc_cnt  (n_earlier),
        .commit_en  (commit_en),
        .keep_lo    (keep_lo),
        .keep_from  (keep_from),
        .new_val    (req_val),
        .new_time   (req_time),
        .ent_val    (ent_val),
        .ent_time   (ent_time),
        .count      (q_count),
        .commit_full(commit_full)
    );

    // Request sequencer: accept, backward scan, commit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state      <= WQ_IDLE;
            req_val    <= '0;
            req_time   <= '0;
            req_rej    <= '0;
            req_inert  <= 1'b0;
            s_ptr      <= '0;
            sched_drop <= 1'b0;
        end else begin
            sched_drop <= 1'b0;
            case (state)
                WQ_IDLE: begin
                    if (accept) begin
                        req_val   <= sched_val;
                        req_time  <= sched_time;
                        req_rej   <= sched_reject;
                        req_inert <= sched_inertial;
                        s_ptr     <= n_earlier;
                        state     <= sched_inertial ? WQ_SCAN : WQ_COMMIT;
                    end
                end
                WQ_SCAN: begin
                    if (pop_fire) begin
                        s_ptr <= (s_ptr == '0) ? '0 : s_dec;
                    end else if (scan_stop) begin
                        state <= WQ_COMMIT;
                    end else begin
                        s_ptr <= s_dec;
                    end
                end
                WQ_COMMIT: begin
                    if (pop_fire) begin
                        s_ptr <= (s_ptr == '0) ? '0 : s_dec;
                    end else begin
                        state      <= WQ_IDLE;
                        sched_drop <= commit_full;
                    end
                end
                default: state <= WQ_IDLE;
            endcase
        end
    end

    // Driven value follows each popped head.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            drv_val <= '0;
        end else if (pop_fire) begin
            drv_val <= ent_val[0];
        end
    end

    // Checker state: non-pop busy cycles of the current request.
    logic [RUN_W-1:0] busy_run;
    always_ff @(posedge clk) begin
        if (!rst_n || !busy) begin
            busy_run <= '0;
        end else if (!pop_fire && busy_run != '1) begin
            busy_run <= busy_run + 1'b1;
        end
    end

    // R11: a request finishes within DEPTH+2 non-pop cycles.
    a_r11_busy_bound: assert property (@(posedge clk) disable iff (!rst_n)
        busy_run <= RUN_W'(DEPTH + 2));

    // R9: no request is taken while busy.
    a_r9_ready_idle: assert property (@(posedge clk) disable iff (!rst_n)
        sched_ready |-> !busy);

    // R10: a head removal blocks acceptance in its cycle.
    a_r10_pop_first: assert property (@(posedge clk) disable iff (!rst_n)
        pop_fire |-> !accept);

    // R8: a drop pulse only follows a full commit.
    a_r8_drop_full: assert property (@(posedge clk) disable iff (!rst_n)
        sched_drop |-> (int'(q_count) == DEPTH));

    // R2: the driven value moves only on a head removal.
    a_r2_drive_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !pop_fire |=> $stable(drv_val));

    // R4: after truncation every pending entry lies before the new time.
    a_r4_truncated: assert property (@(posedge clk) disable iff (!rst_n)
        (state != WQ_IDLE && q_count != '0) |->
            (ent_time[s_idx_tail(q_count)] < req_time));

    function automatic logic [IDX_W-1:0] s_idx_tail(input logic [CNT_W-1:0] c);
        logic [CNT_W-1:0] t;
        t = c - 1'b1;
        return t[IDX_W-1:0];
    endfunction

endmodule

// File: tb/sim_wfq_projq.sv
`timescale 1ns/1ps
// Scoreboard bench: the request task updates a reference list kept by the
// bench, a flush moves expected value changes into a queue, and a monitor
// compares them against drv_val as time advances.
module sim_wfq_projq;

    localparam int DEPTH  = 8;
    localparam int VAL_W  = 16;
    localparam int TIME_W = 32;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [TIME_W-1:0] now_t = '0;
    logic              sv = 1'b0;
    logic [VAL_W-1:0]  sval = '0;
    logic [TIME_W-1:0] stime = '0;
    logic              sinert = 1'b0;
    logic [TIME_W-1:0] srej = '0;
    logic              sched_ready, busy, sched_drop;
    logic [VAL_W-1:0]  drv_val;

    always #2.5 clk = ~clk;

    wfq_projq #(.DEPTH(DEPTH), .VAL_W(VAL_W), .TIME_W(TIME_W)) u0 (
        .clk(clk), .rst_n(rst_n), .now(now_t),
        .sched_valid(sv), .sched_val(sval), .sched_time(stime),
        .sched_inertial(sinert), .sched_reject(srej),
        .sched_ready(sched_ready), .busy(busy), .sched_drop(sched_drop),
        .drv_val(drv_val));

    typedef struct { logic [VAL_W-1:0] v; logic [TIME_W-1:0] n; } item_t;
    item_t exp_q[$];

    logic [VAL_W-1:0]  mv[$];
    logic [TIME_W-1:0] mt[$];
    logic [VAL_W-1:0]  m_drv = '0;
    logic [VAL_W-1:0]  last_drv = '0;
    int n_tests = 0, n_fail = 0;
    bit done = 0;
    int bc;

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint expv);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
        end
    endtask

    // Reference list update, written directly from the requirements.
    function automatic bit model_sched(input logic [VAL_W-1:0] v, input logic [TIME_W-1:0] t,
                                       input bit inert, input logic [TIME_W-1:0] rej);
        bit mk[$];
        logic [VAL_W-1:0]  kv[$];
        logic [TIME_W-1:0] kt[$];
        while (mt.size() > 0 && mt[mt.size()-1] >= t) begin
            void'(mt.pop_back());
            void'(mv.pop_back());
        end
        if (inert) begin
            for (int i = 0; i < mt.size(); i++)
                mk.push_back(({1'b0, mt[i]} + {1'b0, rej}) < {1'b0, t});
            for (int i = mt.size() - 1; i >= 0; i--) begin
                logic [VAL_W-1:0] nv;
                bit nm;
                nv = (i == mt.size() - 1) ? v : mv[i+1];
                nm = (i == mt.size() - 1) ? 1'b1 : mk[i+1];
                if (!mk[i] && nm && mv[i] == nv) mk[i] = 1'b1;
            end
            for (int i = 0; i < mt.size(); i++)
                if (mk[i]) begin kv.push_back(mv[i]); kt.push_back(mt[i]); end
            mv = kv;
            mt = kt;
        end
        if (mt.size() >= DEPTH) return 1'b1;
        mv.push_back(v);
        mt.push_back(t);
        return 1'b0;
    endfunction

    // Driver: present one request, wait for acceptance and completion.
    task automatic do_sched(input logic [VAL_W-1:0] v, input logic [TIME_W-1:0] t,
                            input bit inert, input logic [TIME_W-1:0] rej, output int cycles);
        bit hdrop, mdrop;
        @(posedge clk); #1;
        sv = 1'b1; sval = v; stime = t; sinert = inert; srej = rej;
        do @(negedge clk); while (!sched_ready);
        @(posedge clk); #1;
        sv = 1'b0;
        cycles = 0;
        forever begin
            @(negedge clk);
            if (busy) cycles++;
            else break;
        end
        hdrop = sched_drop;
        mdrop = model_sched(v, t, inert, rej);
        check(hdrop == mdrop, "R8", "drop flag", hdrop, mdrop);
    endtask

    // Move the reference list into the scoreboard and let time run to `upto`.
    // A head of time t pops at the edge that sees now == t; now is bumped 1 ns
    // after that edge, so the monitor observes the change with now == t+1.
    task automatic flush_run(input logic [TIME_W-1:0] upto);
        for (int i = 0; i < mv.size(); i++) begin
            if (mv[i] != m_drv) exp_q.push_back('{v: mv[i], n: mt[i] + 1});
            m_drv = mv[i];
        end
        mv.delete();
        mt.delete();
        while (now_t < upto) begin
            @(posedge clk); #1;
            now_t = now_t + 1;
        end
        repeat (2) @(negedge clk);
        check(exp_q.size() == 0, "R2", "pending expected changes", exp_q.size(), 0);
    endtask

    // Monitor: every drv_val change must match the scoreboard front.
    always @(negedge clk) begin
        if (rst_n && drv_val !== last_drv) begin
            if (exp_q.size() == 0) begin
                check(1'b0, "R2", "unexpected drv_val change", drv_val, last_drv);
            end else begin
                item_t it;
                it = exp_q.pop_front();
                check(drv_val == it.v, "R2", "driven value", drv_val, it.v);
                check(now_t == it.n, "R2", "change instant", now_t, it.n);
            end
            last_drv = drv_val;
        end
    end

    initial begin
        #(5.0 * 150000);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        check(drv_val == 0, "R1", "drv_val after reset", drv_val, 0);
        check(busy == 0, "R1", "busy after reset", busy, 0);
        check(sched_drop == 0, "R1", "sched_drop after reset", sched_drop, 0);
        check(sched_ready == 1, "R9", "ready when idle", sched_ready, 1);

        // R3 append in transport mode; R9 transport takes one busy cycle
        do_sched(16'd1, 32'd10, 1'b0, 32'd0, bc);
        check(bc == 1, "R9", "transport busy cycles", bc, 1);
        do_sched(16'd3, 32'd30, 1'b0, 32'd0, bc);
        do_sched(16'd5, 32'd50, 1'b0, 32'd0, bc);
        // R4: earlier time truncates the 50 entry
        do_sched(16'd4, 32'd40, 1'b0, 32'd0, bc);
        flush_run(32'd60);

        // R6: differing unmarked entry removed; R9 inertial with c = 0
        do_sched(16'd1, 32'd110, 1'b0, 32'd0, bc);
        do_sched(16'd2, 32'd120, 1'b1, 32'd20, bc);
        check(bc == 2, "R9", "inertial busy cycles c=0", bc, 2);
        flush_run(32'd130);

        // R6: same-value run kept; R9 inertial with c = 2
        do_sched(16'd7, 32'd210, 1'b0, 32'd0, bc);
        do_sched(16'd7, 32'd220, 1'b0, 32'd0, bc);
        do_sched(16'd7, 32'd230, 1'b1, 32'd100, bc);
        check(bc == 4, "R9", "inertial busy cycles c=2", bc, 4);
        flush_run(32'd240);

        // R6: run broken by a different value
        do_sched(16'd3, 32'd310, 1'b0, 32'd0, bc);
        do_sched(16'd9, 32'd320, 1'b0, 32'd0, bc);
        do_sched(16'd9, 32'd330, 1'b0, 32'd0, bc);
        do_sched(16'd9, 32'd340, 1'b1, 32'd100, bc);
        flush_run(32'd350);

        // R5: entry earlier than new time minus limit survives
        do_sched(16'd2, 32'd410, 1'b0, 32'd0, bc);
        do_sched(16'd6, 32'd420, 1'b0, 32'd0, bc);
        do_sched(16'd8, 32'd440, 1'b1, 32'd25, bc);
        flush_run(32'd450);

        // R5: limit larger than new time marks nothing
        do_sched(16'd3, 32'd460, 1'b0, 32'd0, bc);
        do_sched(16'd4, 32'd470, 1'b1, 32'd1000, bc);
        flush_run(32'd480);

        // R7: zero limit behaves like transport
        do_sched(16'd1, 32'd510, 1'b0, 32'd0, bc);
        do_sched(16'd2, 32'd520, 1'b0, 32'd0, bc);
        do_sched(16'd3, 32'd530, 1'b1, 32'd0, bc);
        check(bc == 2, "R7", "zero-limit inertial busy cycles", bc, 2);
        flush_run(32'd540);

        // R4: second request at an earlier or equal time replaces the first
        do_sched(16'd5, 32'd620, 1'b0, 32'd0, bc);
        do_sched(16'd6, 32'd610, 1'b1, 32'd10, bc);
        do_sched(16'd1, 32'd700, 1'b0, 32'd0, bc);
        do_sched(16'd2, 32'd700, 1'b0, 32'd0, bc);
        flush_run(32'd710);

        // R8: ninth entry is dropped with a pulse
        for (int i = 0; i < DEPTH; i++)
            do_sched(16'(11 + i), 32'(810 + 10 * i), 1'b0, 32'd0, bc);
        do_sched(16'd99, 32'd890, 1'b0, 32'd0, bc);
        check(sched_drop == 1, "R8", "drop pulse on full list", sched_drop, 1);
        @(negedge clk);
        check(sched_drop == 0, "R8", "drop pulse width", sched_drop, 0);
        flush_run(32'd900);

        // R10: head removal in the same cycle blocks acceptance
        do_sched(16'd4, 32'd1010, 1'b0, 32'd0, bc);
        mv.delete();
        mt.delete();
        exp_q.push_back('{v: 16'd4, n: 32'd1010});
        m_drv = 16'd4;
        while (now_t < 32'd1009) begin
            @(posedge clk); #1;
            now_t = now_t + 1;
        end
        @(posedge clk); #1;
        now_t = 32'd1010;
        sv = 1'b1; sval = 16'd5; stime = 32'd1020; sinert = 1'b0; srej = '0;
        @(negedge clk);
        check(sched_ready == 0, "R10", "ready during head removal", sched_ready, 0);
        @(negedge clk);
        check(sched_ready == 1, "R10", "ready after head removal", sched_ready, 1);
        @(posedge clk); #1;
        sv = 1'b0;
        do @(negedge clk); while (busy);
        void'(model_sched(16'd5, 32'd1020, 1'b0, 32'd0));
        flush_run(32'd1025);
        check(drv_val == 5, "R10", "request taken after removal", drv_val, 5);

        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule